// File: doc/BRIEF.md
# Local-Bus Show-Cycle Mirror

This block sits beside an internal local bus and copies selected local transfers onto a shared system bus as visible "show cycles", so that an external debugger can watch internal traffic. Software writes a 2-bit mode value that decides which local transfers are copied. Reads and writes can both be copied, writes only, or nothing. Out of reset, nothing is copied.

The bridge works on one access at a time. When a qualifying local access is acknowledged, the bridge stores its address, data, direction and size. It asserts the local-bus arbitration request so that no other local master can start a cycle. It then asks for the system bus. Once it holds the grant, it runs the address phase as master and acknowledges that phase itself. It then finishes the data phase as slave in the following cycle.

If the system-bus controller raises the no-show indicator, the bridge withdraws its request for a clock and tries again. A local access that was not acknowledged is not stored. It only makes the bridge keep the local bus for one extra clock. Both buses run on one clock.

Top module: `showcycle_bridge`

## Requirements
- R1: After reset the mode is 2'b11 (off). All outputs are low, and no local access is mirrored until software writes a new mode through `cfg_we`/`cfg_mode`.
- R2: With mode 2'b00, acknowledged local reads and acknowledged local writes (`lb_write`=1 is a write) are both mirrored.
- R3: With mode 2'b01, only writes are mirrored. An acknowledged read causes no `lb_req`, no `busy` and no system-bus activity.
- R4: With mode 2'b10 or 2'b11, no access is mirrored and `lb_req` stays low.
- R5: `lb_req` is high from the cycle after the capturing acknowledge through the address-phase cycle, and low in the data-phase cycle. With grants that are immediate and no back-off, `lb_req` is high for 3 clocks and `sb_ta` comes 4 cycles after the acknowledge cycle, so the whole process takes 5 clocks.
- R6: `sb_req` is driven only in the request phase while `lb_gnt` is high. It stays high for at least 2 consecutive cycles before the address phase, and the address phase starts only after a cycle with `sb_req` and `sb_gnt` both high.
- R7: A qualifying local access with `lb_valid`=1 and `lb_aack`=0 is not captured. It makes `lb_req` high in exactly the next cycle, and the access is captured only when it arrives with `lb_aack`=1.
- R8: The address phase is one cycle with `sb_start` and `sb_aack` both high. The next cycle is the data phase, with `sb_ta` high for one cycle.
- R9: `sb_addr`, `sb_data`, `sb_write` and `sb_size` take the local values from the acknowledge cycle. They hold those values from the cycle after capture until the next capture.
- R10: If `sb_noshow` is high while `sb_req` is high, `sb_req` is low in the next cycle. The request then restarts and again lasts at least 2 cycles.
- R11: `busy` is high from the cycle after capture through the data-phase cycle.
- R12: An access acknowledged during a data-phase cycle is captured. A new request phase follows in the next cycle, and `busy` stays high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock of both buses |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Write strobe for the mode field |
| cfg_mode | input | 2 | New mode value |
| lb_valid | input | 1 | Local access present |
| lb_write | input | 1 | Local access direction, 1 = write |
| lb_size | input | 2 | Local access size code |
| lb_addr | input | AW | Local address |
| lb_data | input | DW | Local data (valid in the acknowledge cycle) |
| lb_aack | input | 1 | Local address acknowledge |
| lb_req | output | 1 | Local-bus arbitration request (hold) |
| lb_gnt | input | 1 | Local-bus grant to this bridge |
| sb_req | output | 1 | System-bus request |
| sb_gnt | input | 1 | System-bus grant |
| sb_noshow | input | 1 | No-show back-off from the system-bus controller |
| sb_start | output | 1 | Address-phase start as master |
| sb_aack | output | 1 | Address acknowledge given by the bridge as slave |
| sb_ta | output | 1 | Data-phase termination given by the bridge as slave |
| sb_write | output | 1 | Mirrored direction |
| sb_size | output | 2 | Mirrored size |
| sb_addr | output | AW | Mirrored address |
| sb_data | output | DW | Mirrored data |
| busy | output | 1 | A show cycle is in progress |

## Verification
The properties assume three things about the inputs:

- Once the bridge holds `lb_req`, the local arbiter keeps `lb_gnt` high until the request drops.
- No local access appears while the bridge holds the local bus.
- The system-bus grant and no-show inputs change only between clock edges.

The stimulus derives `lb_gnt` from `lb_req` through a park enable that changes only while no request phase is running. It drives local accesses only in idle or data-phase cycles. It applies back-off and grant delays only during request phases.

// File: rtl/showcycle_pkg.sv
package showcycle_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_BACK,
    ST_ADDR,
    ST_DATA
  } sc_state_e;

  localparam logic [1:0] MODE_ALL = 2'b00;
  localparam logic [1:0] MODE_WR  = 2'b01;
  localparam logic [1:0] MODE_OFF = 2'b11;

  // decides whether a transfer of the given direction is mirrored in a mode
  function automatic logic mode_qualifies(input logic [1:0] mode, input logic is_write);
    return (mode == MODE_ALL) || ((mode == MODE_WR) && is_write);
  endfunction

endpackage

// File: rtl/showcycle_mode.sv
module showcycle_mode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_mode,
  input  logic       lb_write,
  output logic       qual
);
  import showcycle_pkg::*;

  logic [1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= MODE_OFF;
    else if (cfg_we) mode_q <= cfg_mode;
  end

  assign qual = mode_qualifies(mode_q, lb_write);
endmodule

// File: rtl/showcycle_latch.sv
module showcycle_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/showcycle_seq.sv
module showcycle_seq #(
  parameter int MIN_REQ = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic capture_evt,
  input  logic retry_evt,
  input  logic lb_gnt,
  input  logic sb_gnt,
  input  logic sb_noshow,
  output logic can_accept,
  output logic lb_req,
  output logic sb_req,
  output logic sb_start,
  output logic sb_aack,
  output logic sb_ta,
  output logic busy
);
  import showcycle_pkg::*;

  localparam int CW = $clog2(MIN_REQ + 1);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [CW-1:0] CNEED = CW'(MIN_REQ - 1);

  sc_state_e state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic retry_q;
  logic req_done;

  assign can_accept = (state_q == ST_IDLE) || (state_q == ST_DATA);
  assign sb_req     = (state_q == ST_REQ) && lb_gnt;
  assign req_done   = sb_req && !sb_noshow && sb_gnt && (cnt_q >= CNEED);
  assign sb_start   = (state_q == ST_ADDR);
  assign sb_aack    = (state_q == ST_ADDR);
  assign sb_ta      = (state_q == ST_DATA);
  assign busy       = (state_q != ST_IDLE);
  assign lb_req     = (state_q == ST_REQ) || (state_q == ST_BACK) ||
                      (state_q == ST_ADDR) || retry_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (capture_evt) state_d = ST_REQ;
      ST_REQ: begin
        if (sb_req && sb_noshow) state_d = ST_BACK;
        else if (req_done)       state_d = ST_ADDR;
      end
      ST_BACK: state_d = ST_REQ;
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: state_d = capture_evt ? ST_REQ : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      retry_q <= 1'b0;
    end else begin
      state_q <= state_d;
      retry_q <= retry_evt;
      if ((state_q == ST_REQ) && sb_req)
        cnt_q <= (cnt_q == CMAX) ? cnt_q : cnt_q + CW'(1);
      else
        cnt_q <= '0;
    end
  end
endmodule

// File: rtl/showcycle_bridge.sv
module showcycle_bridge #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int MIN_REQ = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_mode,
  input  logic          lb_valid,
  input  logic          lb_write,
  input  logic [1:0]    lb_size,
  input  logic [AW-1:0] lb_addr,
  input  logic [DW-1:0] lb_data,
  input  logic          lb_aack,
  output logic          lb_req,
  input  logic          lb_gnt,
  output logic          sb_req,
  input  logic          sb_gnt,
  input  logic          sb_noshow,
  output logic          sb_start,
  output logic          sb_aack,
  output logic          sb_ta,
  output logic          sb_write,
  output logic [1:0]    sb_size,
  output logic [AW-1:0] sb_addr,
  output logic [DW-1:0] sb_data,
  output logic          busy
);
  localparam int LW = 1 + 2 + AW + DW;

  logic qual;
  logic can_accept;
  logic capture_evt;
  logic retry_evt;
  logic [LW-1:0] snap_d, snap_q;

  showcycle_mode u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_mode (cfg_mode),
    .lb_write (lb_write),
    .qual     (qual)
  );

  assign capture_evt = lb_valid && lb_aack  && qual && can_accept;
  assign retry_evt   = lb_valid && !lb_aack && qual && can_accept;

  assign snap_d = {lb_write, lb_size, lb_addr, lb_data};

  showcycle_latch #(.W(LW)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (capture_evt),
    .d     (snap_d),
    .q     (snap_q)
  );

  assign {sb_write, sb_size, sb_addr, sb_data} = snap_q;

  showcycle_seq #(.MIN_REQ(MIN_REQ)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture_evt (capture_evt),
    .retry_evt   (retry_evt),
    .lb_gnt      (lb_gnt),
    .sb_gnt      (sb_gnt),
    .sb_noshow   (sb_noshow),
    .can_accept  (can_accept),
    .lb_req      (lb_req),
    .sb_req      (sb_req),
    .sb_start    (sb_start),
    .sb_aack     (sb_aack),
    .sb_ta       (sb_ta),
    .busy        (busy)
  );
endmodule

// File: rtl/showcycle_bridge_chk.sv
module showcycle_bridge_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lb_req,
  input logic          sb_req,
  input logic          sb_gnt,
  input logic          sb_noshow,
  input logic          sb_start,
  input logic          sb_ta,
  input logic          busy,
  input logic [AW-1:0] sb_addr,
  input logic [DW-1:0] sb_data,
  input logic          capture_evt,
  input logic          retry_evt
);
  // R6: a request that is not backed off lasts beyond its first cycle
  a_r6_min_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sb_req) && !sb_noshow |=> sb_req);

  // R6: the address phase follows a granted request
  a_r6_start_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    sb_start |-> $past(sb_req && sb_gnt && !sb_noshow));

  // R8: the data phase follows the address phase directly
  a_r8_data_follows_addr: assert property (@(posedge clk) disable iff (!rst_n)
    sb_start |=> sb_ta);

  // R10: no-show forces the request low in the next cycle
  a_r10_noshow_release: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req && sb_noshow |=> !sb_req);

  // R5: the local bus is held during the address phase
  a_r5_hold_in_addr: assert property (@(posedge clk) disable iff (!rst_n)
    sb_start |-> lb_req);

  // R5: the local bus is free in the data phase
  a_r5_free_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    sb_ta |-> !lb_req);

  // R7: a retried qualifying access holds the local bus for one clock
  a_r7_retry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    retry_evt |=> lb_req);

  // R11: capture makes the block busy
  a_r11_busy_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> busy);

  // R9: mirrored fields do not move during a show cycle
  a_r9_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$past(sb_ta) |-> $stable(sb_addr) && $stable(sb_data));
endmodule

bind showcycle_bridge showcycle_bridge_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/test_showcycle_bridge.sv
`timescale 1ns/1ps
module test_showcycle_bridge;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic lb_valid = 1'b0, lb_write = 1'b0, lb_aack = 1'b0;
  logic [1:0] lb_size = 2'b00;
  logic [AW-1:0] lb_addr = '0;
  logic [DW-1:0] lb_data = '0;
  logic sb_gnt = 1'b1, sb_noshow = 1'b0, gnt_park = 1'b1;
  logic lb_req, lb_gnt, sb_req, sb_start, sb_aack, sb_ta, sb_write, busy;
  logic [1:0] sb_size;
  logic [AW-1:0] sb_addr;
  logic [DW-1:0] sb_data;

  assign lb_gnt = gnt_park & lb_req;

  always #2.5 clk = ~clk;

  showcycle_bridge #(.AW(AW), .DW(DW)) i_showcycle_bridge (.*);

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  int cyc = 0, n_lbreq = 0, n_sbreq = 0, n_busy = 0, n_ta = 0, ta_at = -1, t0 = 0;

  // behavioural reference: phase 0 idle,1 request,2 back-off,3 address,4 data
  int m_mode = 3, m_phase = 0, m_cnt = 0;
  bit m_retry = 0, s_sbreq = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0;
  logic m_write = 1'b0;
  logic [1:0] m_size = 2'b00;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic compare();
    bit e_lbreq;
    e_lbreq = (m_phase >= 1 && m_phase <= 3) || m_retry;
    s_sbreq = (m_phase == 1) && gnt_park && e_lbreq;
    check("R5 lb_req", lb_req, e_lbreq);
    check("R6 sb_req", sb_req, s_sbreq);
    check("R8 sb_start", sb_start, m_phase == 3);
    check("R8 sb_aack", sb_aack, m_phase == 3);
    check("R8 sb_ta", sb_ta, m_phase == 4);
    check("R11 busy", busy, m_phase != 0);
    check("R9 sb_addr", sb_addr, m_addr);
    check("R9 sb_data", sb_data, m_data);
    check("R9 sb_write", sb_write, m_write);
    check("R9 sb_size", sb_size, m_size);
    if (lb_req) n_lbreq++;
    if (sb_req) n_sbreq++;
    if (busy) n_busy++;
    if (sb_ta) begin n_ta++; ta_at = cyc - t0; end
  endtask

  task automatic model_update();
    bit qual, acc, cap, rty;
    int np;
    qual = lb_valid && ((m_mode == 0) || (m_mode == 1 && lb_write));
    acc  = (m_phase == 0) || (m_phase == 4);
    cap  = qual && lb_aack && acc;
    rty  = qual && !lb_aack && acc;
    np = m_phase;
    case (m_phase)
      0: if (cap) np = 1;
      1: if (s_sbreq) begin
           if (sb_noshow) np = 2;
           else if (sb_gnt && m_cnt >= 1) np = 3;
         end
      2: np = 1;
      3: np = 4;
      default: np = cap ? 1 : 0;
    endcase
    m_cnt = (m_phase == 1 && s_sbreq) ? m_cnt + 1 : 0;
    m_retry = rty;
    if (cap) begin
      m_addr = lb_addr; m_data = lb_data; m_write = lb_write; m_size = lb_size;
    end
    if (cfg_we) m_mode = int'(cfg_mode);
    m_phase = np;
  endtask

  task automatic step();
    #1;
    compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
    cyc++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic set_mode(input logic [1:0] m);
    cfg_we = 1'b1; cfg_mode = m;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic start_scn();
    n_lbreq = 0; n_sbreq = 0; n_busy = 0; n_ta = 0; ta_at = -1; t0 = cyc;
  endtask

  task automatic access(input logic wr, input logic ack, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [1:0] sz);
    lb_valid = 1'b1; lb_write = wr; lb_aack = ack; lb_addr = a; lb_data = d; lb_size = sz;
    step();
    lb_valid = 1'b0; lb_aack = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    end
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 lb_req in reset", lb_req, 0);
    check("R1 sb_req in reset", sb_req, 0);
    check("R1 busy in reset", busy, 0);
    check("R1 sb_addr in reset", sb_addr, 0);
    rst_n = 1'b1;
    step();

    // R1: disabled until the mode is written
    start_scn();
    access(1'b1, 1'b1, 32'h1000_0010, 32'hCAFE_0001, 2'b10);
    run(6);
    check("R1 no mirror before mode write", n_busy, 0);
    check("R1 no hold before mode write", n_lbreq, 0);

    // R2/R5: mode 00 write with immediate grants
    set_mode(2'b00);
    start_scn();
    access(1'b1, 1'b1, 32'h2000_0004, 32'h1234_5678, 2'b10);
    run(6);
    check("R5 local hold clocks", n_lbreq, 3);
    check("R5 data phase offset", ta_at, 4);
    check("R11 busy clocks", n_busy, 4);
    check("R6 request clocks", n_sbreq, 2);

    // R2: mode 00 read
    start_scn();
    access(1'b0, 1'b1, 32'h2000_0008, 32'h0BAD_F00D, 2'b01);
    run(6);
    check("R2 read mirrored", n_ta, 1);

    // R3: mode 01 read ignored, write mirrored
    set_mode(2'b01);
    start_scn();
    access(1'b0, 1'b1, 32'h3000_0000, 32'h5555_AAAA, 2'b00);
    run(5);
    check("R3 read no hold", n_lbreq, 0);
    check("R3 read no busy", n_busy, 0);
    start_scn();
    access(1'b1, 1'b1, 32'h3000_0040, 32'h7777_8888, 2'b11);
    run(6);
    check("R3 write mirrored", n_ta, 1);

    // R4: mode 10 reserved and mode 11 off
    set_mode(2'b10);
    start_scn();
    access(1'b1, 1'b1, 32'h4000_0000, 32'h1111_2222, 2'b10);
    access(1'b0, 1'b0, 32'h4000_0004, 32'h3333_4444, 2'b10);
    run(5);
    check("R4 reserved mode no hold", n_lbreq, 0);
    set_mode(2'b11);
    start_scn();
    access(1'b1, 1'b1, 32'h4000_0010, 32'h9999_0000, 2'b10);
    run(5);
    check("R4 off mode no busy", n_busy, 0);

    // R7: retried access
    set_mode(2'b00);
    start_scn();
    access(1'b1, 1'b0, 32'h5000_0000, 32'hDEAD_BEEF, 2'b10);
    step();
    access(1'b1, 1'b1, 32'h5000_0000, 32'hDEAD_BEEF, 2'b10);
    run(6);
    check("R7 hold clocks incl retry", n_lbreq, 4);
    check("R7 data phase offset", ta_at, 6);

    // R10: no-show during first request cycle
    start_scn();
    access(1'b1, 1'b1, 32'h6000_0000, 32'hA5A5_5A5A, 2'b10);
    sb_noshow = 1'b1;
    step();
    sb_noshow = 1'b0;
    run(7);
    check("R10 data phase offset", ta_at, 6);
    check("R10 request clocks", n_sbreq, 3);

    // R6: delayed system-bus grant
    start_scn();
    access(1'b0, 1'b1, 32'h7000_0000, 32'h0F0F_F0F0, 2'b01);
    sb_gnt = 1'b0;
    run(3);
    sb_gnt = 1'b1;
    run(5);
    check("R6 delayed grant offset", ta_at, 6);
    check("R6 delayed grant request clocks", n_sbreq, 4);

    // R6: local grant withheld
    start_scn();
    gnt_park = 1'b0;
    access(1'b1, 1'b1, 32'h7100_0000, 32'h1357_9BDF, 2'b10);
    run(2);
    gnt_park = 1'b1;
    run(5);
    check("R6 no request without local grant", n_sbreq, 2);
    check("R6 withheld grant offset", ta_at, 6);

    // R12: back-to-back capture in the data-phase cycle
    start_scn();
    access(1'b1, 1'b1, 32'h8000_0000, 32'h0000_0001, 2'b10);
    run(3);
    access(1'b1, 1'b1, 32'h8000_0004, 32'h0000_0002, 2'b10);
    run(6);
    check("R12 two data phases", n_ta, 2);
    check("R12 second data phase offset", ta_at, 8);
    check("R12 busy continuous", n_busy, 8);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    end
    $finish;
  end
endmodule